// File: doc/BRIEF.md
# Power-Up Self-Test and State-Clearing Sequencer

This block runs a self-test once a power-up request arrives. It first drives a 64-bit pseudo-random pattern from a shift-register generator into the functional units for a fixed number of cycles. The units' responses are folded into a signature by a separate compactor outside this block. Next, the block walks an address counter across a register file and raises a clear strobe for one entry per cycle. This spreads the return to a known zero state over many cycles, so no die-wide reset net is needed. Last, it samples the compactor's signature once and compares it with a constant computed offline. The result is reported on a pass output that is qualified by a done flag.

The pattern length, the register-file depth, the seed and the expected signature are parameters. A simulation configuration uses a short run in place of the roughly hundred-thousand-cycle production run. A build parameter removes the test logic entirely for prototype builds. In that case a request completes at once and reports success.

Top module: `pwrup_bist_seq`

## Requirements
- R1: After reset, busy_o, done_o, pass_o, stim_valid_o and rf_clr_o are 0, and stim_o is 0.
- R2: A start_i pulse seen in idle raises busy_o from the next cycle for exactly RUN_CYCLES + RF_DEPTH + 1 cycles. After those cycles, done_o is 1 and busy_o is 0. busy_o and done_o are never high together.
- R3: During the first RUN_CYCLES busy cycles, stim_valid_o is 1. stim_o equals SEED in the first of these cycles. In each later cycle, stim_o is the previous value shifted left by one, with bit 0 set to the XOR of the previous bits 63, 62, 60 and 59. Outside this phase, stim_valid_o and stim_o are 0.
- R4: Right after the pattern phase, rf_clr_o is 1 for RF_DEPTH consecutive cycles. During those cycles rf_addr_o counts up from 0 to RF_DEPTH-1, one entry per cycle.
- R5: The cycle after the last clear is a compare cycle. resp_sig_i is sampled at the end of it. In the following DONE state, pass_o is 1 exactly when that sample equals EXPECT_SIG.
- R6: pass_o is 0 whenever done_o is 0.
- R7: start_i while busy_o is 1 has no effect. The stimulus, the clear sequence and the cycle of done_o are unchanged.
- R8: done_o and pass_o hold until the next start_i. A start_i in the done state runs the whole sequence again from SEED.
- R9: With BIST_EN = 0, a start_i pulse gives done_o = 1 and pass_o = 1 from the next cycle. In that build, busy_o, stim_valid_o and rf_clr_o stay 0.
- R10: resp_sig_i has no effect on pass_o in any cycle other than the compare cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Power-up test request (pulse) |
| resp_sig_i | input | 64 | Signature from the external response compactor |
| stim_o | output | 64 | Pseudo-random stimulus to the functional units |
| stim_valid_o | output | 1 | Stimulus phase active |
| rf_clr_o | output | 1 | Write zero to the addressed register-file entry |
| rf_addr_o | output | ADDR_W | Entry being cleared |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished |
| pass_o | output | 1 | Signature matched (meaningful only with done_o) |

## Verification
The assertions assume that reset is held for at least one clock edge before the first request. The stepping checks also rely on a nonzero seed, because the generator must never reach the all-zero state. The bench holds reset for several cycles and uses a nonzero seed. It drives start_i and resp_sig_i only at falling edges, including requests placed in the middle of the pattern and clear phases. Outside the compare cycle, it holds resp_sig_i at a wrong value, so only the sample from the compare cycle can decide pass_o.

// File: rtl/bist_pkg.sv
package bist_pkg;

    localparam int PAT_W = 64;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RUN,
        ST_CLEAR,
        ST_CMP,
        ST_DONE
    } bist_state_e;

    // Fibonacci feedback from taps 64, 63, 61, 60 (bits 63, 62, 60, 59)
    function automatic logic [PAT_W-1:0] pat_next(input logic [PAT_W-1:0] cur);
        logic fb;
        fb = cur[63] ^ cur[62] ^ cur[60] ^ cur[59];
        return {cur[PAT_W-2:0], fb};
    endfunction

endpackage

// File: rtl/bist_pattern_gen.sv
module bist_pattern_gen
    import bist_pkg::*;
#(
    parameter logic [PAT_W-1:0] SEED = 64'h1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic             adv_i,
    output logic [PAT_W-1:0] pat_o
);
    logic [PAT_W-1:0] pat_q;

    always_ff @(posedge clk) begin
        if (rst)         pat_q <= SEED;
        else if (load_i) pat_q <= SEED;
        else if (adv_i)  pat_q <= pat_next(pat_q);
    end

    assign pat_o = pat_q;

    // R3: a nonzero seed never lets the register collapse to zero
    p_pat_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
        adv_i |-> pat_q != '0);
endmodule

// File: rtl/bist_clear_walk.sv
module bist_clear_walk #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go_i,
    output logic              active_o,
    output logic              last_o,
    output logic [ADDR_W-1:0] addr_o
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

    logic              active_q;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            addr_q   <= '0;
        end else if (go_i) begin
            active_q <= 1'b1;
            addr_q   <= '0;
        end else if (active_q) begin
            if (addr_q == LAST_ADDR) begin
                active_q <= 1'b0;
                addr_q   <= '0;
            end else begin
                addr_q <= addr_q + 1'b1;
            end
        end
    end

    assign active_o = active_q;
    assign last_o   = active_q && (addr_q == LAST_ADDR);
    assign addr_o   = addr_q;

    // R4: consecutive clear cycles visit consecutive entries
    p_addr_step_r4: assert property (@(posedge clk) disable iff (rst)
        active_q && $past(active_q) |-> addr_q == $past(addr_q) + 1'b1);
endmodule

// File: rtl/pwrup_bist_seq.sv
module pwrup_bist_seq
    import bist_pkg::*;
#(
    parameter int               RUN_CYCLES = 100000,
    parameter int               RF_DEPTH   = 64,
    parameter logic [PAT_W-1:0] SEED       = 64'h0000_0000_0000_0001,
    parameter logic [PAT_W-1:0] EXPECT_SIG = 64'h5A5A_0F0F_3C3C_9696,
    parameter bit               BIST_EN    = 1'b1,
    localparam int              ADDR_W     = (RF_DEPTH > 1) ? $clog2(RF_DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [PAT_W-1:0]  resp_sig_i,
    output logic [PAT_W-1:0]  stim_o,
    output logic              stim_valid_o,
    output logic              rf_clr_o,
    output logic [ADDR_W-1:0] rf_addr_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              pass_o
);
    localparam int RUN_W = (RUN_CYCLES > 1) ? $clog2(RUN_CYCLES) : 1;
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_CYCLES - 1);

    generate
        if (BIST_EN) begin : g_bist
            bist_state_e      state_q;
            logic [RUN_W-1:0] run_cnt_q;
            logic             pass_q;
            logic             launch;
            logic             run_last;
            logic             clr_last;
            logic             clr_active;
            logic [PAT_W-1:0] pat;

            assign launch   = start_i && (state_q == ST_IDLE || state_q == ST_DONE);
            assign run_last = (state_q == ST_RUN) && (run_cnt_q == RUN_LAST);

            bist_pattern_gen #(.SEED(SEED)) u_pat (
                .clk    (clk),
                .rst    (rst),
                .load_i (launch),
                .adv_i  (state_q == ST_RUN),
                .pat_o  (pat)
            );

            bist_clear_walk #(.DEPTH(RF_DEPTH), .ADDR_W(ADDR_W)) u_clr (
                .clk      (clk),
                .rst      (rst),
                .go_i     (run_last),
                .active_o (clr_active),
                .last_o   (clr_last),
                .addr_o   (rf_addr_o)
            );

            always_ff @(posedge clk) begin
                if (rst) begin
                    state_q   <= ST_IDLE;
                    run_cnt_q <= '0;
                    pass_q    <= 1'b0;
                end else begin
                    case (state_q)
                        ST_IDLE, ST_DONE: begin
                            if (launch) begin
                                state_q   <= ST_RUN;
                                run_cnt_q <= '0;
                                pass_q    <= 1'b0;
                            end
                        end
                        ST_RUN: begin
                            if (run_last) state_q <= ST_CLEAR;
                            else          run_cnt_q <= run_cnt_q + 1'b1;
                        end
                        ST_CLEAR: begin
                            if (clr_last) state_q <= ST_CMP;
                        end
                        ST_CMP: begin
                            pass_q  <= (resp_sig_i == EXPECT_SIG);
                            state_q <= ST_DONE;
                        end
                        default: state_q <= ST_IDLE;
                    endcase
                end
            end

            assign stim_valid_o = (state_q == ST_RUN);
            assign stim_o       = stim_valid_o ? pat : '0;
            assign rf_clr_o     = clr_active;
            assign busy_o       = (state_q == ST_RUN) || (state_q == ST_CLEAR) ||
                                  (state_q == ST_CMP);
            assign done_o       = (state_q == ST_DONE);
            assign pass_o       = done_o && pass_q;

            p_pass_needs_done_r6: assert property (@(posedge clk) disable iff (rst)
                pass_o |-> done_o);
            p_busy_done_excl_r2: assert property (@(posedge clk) disable iff (rst)
                !(busy_o && done_o));
            p_stim_quiet_r3: assert property (@(posedge clk) disable iff (rst)
                !stim_valid_o |-> stim_o == '0);
            p_run_to_clear_r4: assert property (@(posedge clk) disable iff (rst)
                $fell(stim_valid_o) |-> rf_clr_o && busy_o);
            p_clear_to_cmp_r5: assert property (@(posedge clk) disable iff (rst)
                $fell(rf_clr_o) |-> busy_o && !done_o && !stim_valid_o);
            p_start_ignored_r7: assert property (@(posedge clk) disable iff (rst)
                (state_q == ST_RUN) && !run_last && start_i |=> state_q == ST_RUN);
        end else begin : g_bypass
            logic done_q;

            always_ff @(posedge clk) begin
                if (rst)          done_q <= 1'b0;
                else if (start_i) done_q <= 1'b1;
            end

            assign stim_o       = '0;
            assign stim_valid_o = 1'b0;
            assign rf_clr_o     = 1'b0;
            assign rf_addr_o    = '0;
            assign busy_o       = 1'b0;
            assign done_o       = done_q;
            assign pass_o       = done_q;

            p_bypass_idle_r9: assert property (@(posedge clk) disable iff (rst)
                !busy_o && !rf_clr_o);
        end
    endgenerate
endmodule

// File: tb/pwrup_bist_seq_tb.sv
module pwrup_bist_seq_tb_top;
    localparam int          CLK_PERIOD = 10;
    localparam int          RUN_N      = 40;
    localparam int          DEPTH      = 8;
    localparam logic [63:0] SEED_V     = 64'h0000_0000_0000_0001;
    localparam logic [63:0] GOOD_SIG   = 64'h5A5A_0F0F_3C3C_9696;
    localparam int          AW         = $clog2(DEPTH);
    localparam int          WDOG       = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_on = 1'b0;
    logic        start_off = 1'b0;
    logic [63:0] sig = 64'h0;

    logic [63:0]   stim, stim_x;
    logic          sv, sv_x, clr, clr_x, busy, busy_x, done, done_x, pass, pass_x;
    logic [AW-1:0] addr, addr_x;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pwrup_bist_seq #(.RUN_CYCLES(RUN_N), .RF_DEPTH(DEPTH), .SEED(SEED_V),
                     .EXPECT_SIG(GOOD_SIG), .BIST_EN(1'b1)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_on), .resp_sig_i(sig),
        .stim_o(stim), .stim_valid_o(sv), .rf_clr_o(clr), .rf_addr_o(addr),
        .busy_o(busy), .done_o(done), .pass_o(pass));

    pwrup_bist_seq #(.RUN_CYCLES(RUN_N), .RF_DEPTH(DEPTH), .SEED(SEED_V),
                     .EXPECT_SIG(GOOD_SIG), .BIST_EN(1'b0)) dut_off_i (
        .clk(clk), .rst(rst), .start_i(start_off), .resp_sig_i(sig),
        .stim_o(stim_x), .stim_valid_o(sv_x), .rf_clr_o(clr_x), .rf_addr_o(addr_x),
        .busy_o(busy_x), .done_o(done_x), .pass_o(pass_x));

    function automatic logic [63:0] model_step(input logic [63:0] v);
        return {v[62:0], v[63] ^ v[62] ^ v[60] ^ v[59]};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == WDOG && !finished) begin
            finished = 1'b1;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // One complete sequence; a start pulse is injected at pattern cycle inj_run
    // and at clear cycle inj_clr (R7); sig is wrong outside the compare cycle (R10).
    task automatic run_seq(input logic [63:0] cmp_sig, input bit exp_pass,
                           input int inj_run, input int inj_clr);
        logic [63:0] pat;
        pat = SEED_V;
        start_on = 1'b1;
        @(negedge clk);
        start_on = 1'b0;
        for (int j = 0; j < RUN_N; j++) begin
            chk("R2 busy in pattern", 64'(busy), 64'd1);
            chk("R3 stim_valid", 64'(sv), 64'd1);
            chk("R3 stim value", stim, pat);
            chk("R4 no clear in pattern", 64'(clr), 64'd0);
            chk("R6 pass low while busy", 64'(pass), 64'd0);
            sig = ~GOOD_SIG ^ 64'(j);
            start_on = (j == inj_run);
            pat = model_step(pat);
            @(negedge clk);
        end
        start_on = 1'b0;
        for (int a = 0; a < DEPTH; a++) begin
            chk("R4 clear strobe", 64'(clr), 64'd1);
            chk("R4 clear address", 64'(addr), 64'(a));
            chk("R3 stim quiet in clear", {stim[62:0], sv}, 64'd0);
            chk("R2 busy in clear", 64'(busy), 64'd1);
            start_on = (a == inj_clr);
            @(negedge clk);
        end
        start_on = 1'b0;
        chk("R5 compare cycle busy", 64'(busy), 64'd1);
        chk("R5 compare cycle no clear", 64'(clr), 64'd0);
        chk("R6 no done in compare", {62'd0, done, pass}, 64'd0);
        sig = cmp_sig;
        @(negedge clk);
        sig = GOOD_SIG ^ 64'h1;
        chk("R2 done after run", {62'd0, busy, done}, 64'd1);
        chk("R5 pass result", 64'(pass), 64'(exp_pass));
        for (int k = 0; k < 3; k++) begin
            sig = (k == 1) ? GOOD_SIG : ~GOOD_SIG;
            @(negedge clk);
            chk("R8 done holds", 64'(done), 64'd1);
            chk("R10 pass unaffected after compare", 64'(pass), 64'(exp_pass));
        end
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R1 reset outputs", {59'd0, busy, done, pass, sv, clr}, 64'd0);
        chk("R1 reset stim", stim, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 idle after reset", {59'd0, busy, done, pass, sv, clr}, 64'd0);

        // R9: bypass build
        start_off = 1'b1;
        @(negedge clk);
        start_off = 1'b0;
        chk("R9 bypass done/pass", {62'd0, done_x, pass_x}, 64'd3);
        chk("R9 bypass quiet", {61'd0, busy_x, sv_x, clr_x}, 64'd0);
        chk("R9 bypass stim", stim_x, 64'd0);

        // good signature, start injected during pattern and clear (R7)
        run_seq(GOOD_SIG, 1'b1, 5, 3);
        // R8: restart from done with a wrong signature
        run_seq(GOOD_SIG ^ 64'h8000_0000_0000_0000, 1'b0, RUN_N - 1, DEPTH - 1);
        // R8: restart again with the good one, injections at phase starts
        run_seq(GOOD_SIG, 1'b1, 0, 0);

        chk("R9 bypass still quiet", {61'd0, busy_x, sv_x, clr_x}, 64'd0);

        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule